// File: doc/BRIEF.md
# Background Debug State Controller

This block sits beside a processor core and manages the core's halted debug state. It watches every completed bus cycle and records the address of the most recent one. After a bus error or address error, that address is therefore the address of the faulting cycle. The block enters debug state when a breakpoint request or a double bus fault arrives. On entry it captures where the core stopped, and it raises a freeze output. While that freeze output is high, a select output gives the shared pins to the serial debug path.

During debug state a host can read the captured registers and can rewrite the return pointer and the supervisor flag. Only a resume command or a call command ends the state. Exit always follows the same order:
1. A one-cycle pipeline flush pulse.
2. Freeze is released.
3. The shared pins return to their pipeline-status role.
4. A prefetch request is issued at the return pointer, and it is held until acknowledged.

If the return pointer is odd, an address-error pulse takes the place of the prefetch request.

Top module: `bdm_ctrl`

## Requirements
- R1: After reset, freeze, flush, pin_dbg_sel, pf_start and pf_addr_err are low. supv is high. Register reads at selects 0 (fault address), 1 (return pointer) and 2 (instruction pointer) return 0.
- R2: In every cycle with bus_valid high, the fault address register loads bus_addr. It holds its value in all other cycles, so after two faulting cycles in a row it holds the address of the second. Its value is read at reg_sel 0.
- R3: In the normal state, bkpt_req or dbl_fault moves the block to debug state at the next clock edge, where freeze and pin_dbg_sel go high. At that same edge the return pointer (reg_sel 1) loads entry_rpc, and the instruction pointer (reg_sel 2) loads the retire_pc of the most recent retire_valid cycle.
- R4: If the entry is caused by dbl_fault and no retire_valid has been seen since reset, the instruction pointer reads 0x00000001.
- R5: In debug state, a write at reg_sel 1 replaces the return pointer, and a write at reg_sel 3 sets the pending supervisor flag from bit 0. The pending flag reads back at reg_sel 3. The supv output takes the pending value only at the edge where exit begins. Writes at reg_sel 0 or 2, and all writes outside debug state, are ignored.
- R6: In debug state, cmd_valid with cmd_code 1 (resume) or 2 (call) starts exit. In the following cycle flush is high for exactly one cycle while freeze is still high.
- R7: One cycle after the flush pulse, freeze is low while pin_dbg_sel is still high. One cycle later pin_dbg_sel is low.
- R8: In the cycle after pin_dbg_sel falls, if the return pointer is even, pf_start is high with pf_addr equal to the return pointer. It stays high until pf_ack is seen at a clock edge, and the block is then in the normal state.
- R9: If the return pointer is odd at that point, pf_start stays low. pf_addr_err is high for exactly one cycle instead, and the block returns to the normal state.
- R10: In debug state, a cmd_valid with any other cmd_code keeps freeze high and produces no flush and no prefetch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_addr | input | AW | Address of that bus cycle |
| bkpt_req | input | 1 | Breakpoint request to enter debug state |
| dbl_fault | input | 1 | Double bus fault; enters debug state |
| retire_valid | input | 1 | An instruction completes this clock |
| retire_pc | input | AW | Address of that instruction's first word |
| entry_rpc | input | AW | Next fetch address, captured on entry |
| cmd_valid | input | 1 | Debug command strobe |
| cmd_code | input | 3 | Command code (1 resume, 2 call) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Selected register value (combinational) |
| freeze | output | 1 | Core is held in debug state |
| flush | output | 1 | One-cycle pipeline flush pulse |
| pin_dbg_sel | output | 1 | Shared pins serve the serial debug path |
| pf_start | output | 1 | First prefetch request after exit |
| pf_addr | output | AW | Prefetch address |
| pf_ack | input | 1 | Prefetch request accepted |
| pf_addr_err | output | 1 | Odd return pointer at prefetch start |
| supv | output | 1 | Live supervisor flag |

## Verification
Entry is registered once, so freeze and the captured registers change one edge after the request. The bench samples them at the next falling edge. After an exit command, flush, the freeze release, the pin release and the prefetch request (or address-error pulse) are due one, two, three and three edges later. The bench steps one falling edge at a time and checks each output's value in its own cycle. Register reads are combinational and are sampled one time unit after reg_sel changes. A fault-address update is visible one edge after its bus cycle.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_FLUSH = 3'd2,
    ST_THAW  = 3'd3,
    ST_FETCH = 3'd4
  } bdm_state_t;

  localparam logic [2:0] CMD_RESUME = 3'd1;
  localparam logic [2:0] CMD_CALL   = 3'd2;

  localparam logic [1:0] SEL_FAULT = 2'd0;
  localparam logic [1:0] SEL_RET   = 2'd1;
  localparam logic [1:0] SEL_INSN  = 2'd2;
  localparam logic [1:0] SEL_SUPV  = 2'd3;

  function automatic logic leaves_halt(input logic [2:0] code);
    return (code == CMD_RESUME) || (code == CMD_CALL);
  endfunction

  // Instruction pointer captured at entry: marker 1 for a double fault
  // before any instruction has completed, else newest completed address.
  function automatic logic [31:0] insn_ptr_at_entry(
      input logic dbl, input logic seen, input logic [31:0] newest);
    return (dbl && !seen) ? 32'h0000_0001 : newest;
  endfunction

  function automatic logic misaligned(input logic lsb);
    return lsb;
  endfunction

endpackage

// File: rtl/bdm_fault_addr.sv
module bdm_fault_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  output logic [AW-1:0] fault_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n)         fault_addr <= '0;
    else if (bus_valid) fault_addr <= bus_addr;
  end

  a_r2_fault_addr_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && bus_valid) |=> (fault_addr == $past(bus_addr)));

  a_r2_fault_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !bus_valid) |=> $stable(fault_addr));

endmodule

// File: rtl/bdm_pc_file.sv
module bdm_pc_file
  import bdm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_evt,
  input  logic          exit_evt,
  input  logic          halted,
  input  logic          dbl_fault,
  input  logic          retire_valid,
  input  logic [AW-1:0] retire_pc,
  input  logic [AW-1:0] entry_rpc,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] ret_ptr,
  output logic [AW-1:0] insn_ptr,
  output logic          supv_pend,
  output logic          supv
);

  logic [AW-1:0] last_pc;
  logic          seen_retire;
  logic [AW-1:0] newest_pc;
  logic [31:0]   ptr_wide;
  logic [31:0]   newest_wide;
  logic          wr_ret;
  logic          wr_supv;

  assign newest_pc = retire_valid ? retire_pc : last_pc;
  assign wr_ret    = halted && reg_wr && (reg_sel == SEL_RET);
  assign wr_supv   = halted && reg_wr && (reg_sel == SEL_SUPV);

  always_comb begin
    newest_wide = '0;
    newest_wide[AW-1:0] = newest_pc;
    ptr_wide = insn_ptr_at_entry(dbl_fault, seen_retire || retire_valid, newest_wide);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pc     <= '0;
      seen_retire <= 1'b0;
    end else if (retire_valid) begin
      last_pc     <= retire_pc;
      seen_retire <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_ptr   <= '0;
      insn_ptr  <= '0;
      supv_pend <= 1'b1;
      supv      <= 1'b1;
    end else begin
      if (enter_evt) begin
        ret_ptr   <= entry_rpc;
        insn_ptr  <= ptr_wide[AW-1:0];
        supv_pend <= supv;
      end else begin
        if (wr_ret)  ret_ptr   <= reg_wdata;
        if (wr_supv) supv_pend <= reg_wdata[0];
      end
      if (exit_evt) supv <= supv_pend;
    end
  end

  a_r5_supv_only_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !exit_evt) |=> $stable(supv));

  a_r5_ret_ptr_frozen_outside_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !halted && !enter_evt) |=> $stable(ret_ptr));

endmodule

// File: rtl/bdm_exit_fsm.sv
module bdm_exit_fsm
  import bdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       ret_lsb,
  input  logic       pf_ack,
  output logic       enter_evt,
  output logic       exit_evt,
  output logic       halted,
  output logic       freeze,
  output logic       flush,
  output logic       pin_dbg_sel,
  output logic       pf_start,
  output logic       pf_addr_err
);

  bdm_state_t state, state_nx;
  logic       other_cmd;

  assign halted    = (state == ST_HALT);
  assign enter_evt = (state == ST_RUN) && enter_req;
  assign exit_evt  = halted && cmd_valid && leaves_halt(cmd_code);
  assign other_cmd = halted && cmd_valid && !leaves_halt(cmd_code);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:   if (enter_req) state_nx = ST_HALT;
      ST_HALT:  if (exit_evt)  state_nx = ST_FLUSH;
      ST_FLUSH: state_nx = ST_THAW;
      ST_THAW:  state_nx = ST_FETCH;
      ST_FETCH: if (misaligned(ret_lsb) || pf_ack) state_nx = ST_RUN;
      default:  state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  assign freeze      = (state == ST_HALT) || (state == ST_FLUSH);
  assign flush       = (state == ST_FLUSH);
  assign pin_dbg_sel = freeze || (state == ST_THAW);
  assign pf_start    = (state == ST_FETCH) && !misaligned(ret_lsb);
  assign pf_addr_err = (state == ST_FETCH) && misaligned(ret_lsb);

  a_r6_flush_follows_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && exit_evt) |=> (flush && freeze));

  a_r6_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  a_r7_freeze_drops_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze) |-> $past(flush));

  a_r7_pins_after_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_dbg_sel) |-> (!freeze && $past(!freeze)));

  a_r8_fetch_unfrozen: assert property (@(posedge clk) disable iff (!rst_n)
    pf_start |-> (!freeze && !pin_dbg_sel));

  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    pf_addr_err |=> (!pf_addr_err && !pf_start));

  a_r10_other_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && other_cmd) |=> (freeze && !flush && !pf_start));

endmodule

// File: rtl/bdm_ctrl.sv
module bdm_ctrl
  import bdm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bkpt_req,
  input  logic          dbl_fault,
  input  logic          retire_valid,
  input  logic [AW-1:0] retire_pc,
  input  logic [AW-1:0] entry_rpc,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          freeze,
  output logic          flush,
  output logic          pin_dbg_sel,
  output logic          pf_start,
  output logic [AW-1:0] pf_addr,
  input  logic          pf_ack,
  output logic          pf_addr_err,
  output logic          supv
);

  logic [AW-1:0] fault_addr;
  logic [AW-1:0] ret_ptr;
  logic [AW-1:0] insn_ptr;
  logic          supv_pend;
  logic          enter_evt;
  logic          exit_evt;
  logic          halted;

  bdm_fault_addr #(.AW(AW)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .fault_addr (fault_addr)
  );

  bdm_exit_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_req   (bkpt_req || dbl_fault),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .ret_lsb     (ret_ptr[0]),
    .pf_ack      (pf_ack),
    .enter_evt   (enter_evt),
    .exit_evt    (exit_evt),
    .halted      (halted),
    .freeze      (freeze),
    .flush       (flush),
    .pin_dbg_sel (pin_dbg_sel),
    .pf_start    (pf_start),
    .pf_addr_err (pf_addr_err)
  );

  bdm_pc_file #(.AW(AW)) u_pcs (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_evt    (enter_evt),
    .exit_evt     (exit_evt),
    .halted       (halted),
    .dbl_fault    (dbl_fault),
    .retire_valid (retire_valid),
    .retire_pc    (retire_pc),
    .entry_rpc    (entry_rpc),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .ret_ptr      (ret_ptr),
    .insn_ptr     (insn_ptr),
    .supv_pend    (supv_pend),
    .supv         (supv)
  );

  assign pf_addr = ret_ptr;

  always_comb begin
    unique case (reg_sel)
      SEL_FAULT: reg_rdata = fault_addr;
      SEL_RET:   reg_rdata = ret_ptr;
      SEL_INSN:  reg_rdata = insn_ptr;
      default:   reg_rdata = {{(AW-1){1'b0}}, supv_pend};
    endcase
  end

  a_r3_entry_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && enter_evt) |=> (freeze && pin_dbg_sel && (ret_ptr == $past(entry_rpc))));

  a_r8_fetch_addr_even: assert property (@(posedge clk) disable iff (!rst_n)
    pf_start |-> !pf_addr[0]);

endmodule

// File: tb/bdm_ctrl_tb.sv
module bdm_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bkpt_req = 1'b0;
  logic          dbl_fault = 1'b0;
  logic          retire_valid = 1'b0;
  logic [AW-1:0] retire_pc = '0;
  logic [AW-1:0] entry_rpc = '0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_code = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          freeze, flush, pin_dbg_sel, pf_start, pf_addr_err, supv;
  logic [AW-1:0] pf_addr;
  logic          pf_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bdm_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bkpt_req(bkpt_req), .dbl_fault(dbl_fault), .retire_valid(retire_valid),
    .retire_pc(retire_pc), .entry_rpc(entry_rpc), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .freeze(freeze),
    .flush(flush), .pin_dbg_sel(pin_dbg_sel), .pf_start(pf_start),
    .pf_addr(pf_addr), .pf_ack(pf_ack), .pf_addr_err(pf_addr_err), .supv(supv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] sel, output logic [AW-1:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [AW-1:0] data);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic enter(input bit use_dbl, input logic [AW-1:0] rpc);
    entry_rpc = rpc;
    if (use_dbl) dbl_fault = 1'b1; else bkpt_req = 1'b1;
    step();
    dbl_fault = 1'b0; bkpt_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    chk("R1 freeze", freeze, 0);
    chk("R1 flush", flush, 0);
    chk("R1 pin_dbg_sel", pin_dbg_sel, 0);
    chk("R1 pf_start", pf_start, 0);
    chk("R1 pf_addr_err", pf_addr_err, 0);
    chk("R1 supv", supv, 1);
    read_reg(2'd0, v); chk("R1 fault addr", v, 0);
    read_reg(2'd1, v); chk("R1 ret ptr", v, 0);
    read_reg(2'd2, v); chk("R1 insn ptr", v, 0);
  endtask

  // exits with the given command and checks every cycle of the ordering
  task automatic exit_seq(input logic [2:0] code, input logic [AW-1:0] rpc);
    cmd_valid = 1'b1; cmd_code = code;
    step();
    cmd_valid = 1'b0;
    chk("R6 flush pulse", flush, 1);
    chk("R6 freeze during flush", freeze, 1);
    step();
    chk("R6 flush single", flush, 0);
    chk("R7 freeze low", freeze, 0);
    chk("R7 pins still debug", pin_dbg_sel, 1);
    chk("R7 no early fetch", pf_start, 0);
    step();
    chk("R7 pins released", pin_dbg_sel, 0);
    if (rpc[0]) begin
      chk("R9 no fetch on odd", pf_start, 0);
      chk("R9 addr err pulse", pf_addr_err, 1);
      step();
      chk("R9 addr err single", pf_addr_err, 0);
      chk("R9 back to run", freeze, 0);
    end else begin
      chk("R8 fetch start", pf_start, 1);
      chk("R8 fetch addr", pf_addr, rpc);
      chk("R8 no addr err", pf_addr_err, 0);
      step();
      chk("R8 fetch held", pf_start, 1);
      pf_ack = 1'b1;
      step();
      pf_ack = 1'b0;
      chk("R8 fetch done", pf_start, 0);
      chk("R8 run state", freeze, 0);
    end
  endtask

  task automatic t_dbl_after_reset();
    logic [AW-1:0] v;
    enter(1'b1, 32'h0000_4000);
    chk("R3 freeze on dbl", freeze, 1);
    chk("R3 pins on dbl", pin_dbg_sel, 1);
    read_reg(2'd2, v); chk("R4 insn ptr marker", v, 32'h1);
    read_reg(2'd1, v); chk("R3 ret ptr", v, 32'h0000_4000);
    exit_seq(3'd1, 32'h0000_4000);
  endtask

  task automatic t_fault_addr();
    logic [AW-1:0] v;
    bus_valid = 1'b1; bus_addr = 32'h0000_1230;
    step();
    bus_addr = 32'h0000_5678;
    step();
    bus_valid = 1'b0; bus_addr = 32'hDEAD_BEEF;
    step();
    step();
    read_reg(2'd0, v); chk("R2 last cycle kept", v, 32'h0000_5678);
  endtask

  task automatic t_bkpt_entry();
    logic [AW-1:0] v;
    retire_valid = 1'b1; retire_pc = 32'h0000_2000;
    step();
    retire_pc = 32'h0000_2004;
    step();
    retire_valid = 1'b0;
    step();
    enter(1'b0, 32'h0000_2008);
    chk("R3 freeze on bkpt", freeze, 1);
    read_reg(2'd2, v); chk("R3 insn ptr", v, 32'h0000_2004);
    read_reg(2'd1, v); chk("R3 ret ptr", v, 32'h0000_2008);
  endtask

  task automatic t_writes_and_call();
    logic [AW-1:0] v;
    write_reg(2'd1, 32'h0000_3000);
    write_reg(2'd3, 32'h0);
    write_reg(2'd0, 32'hFFFF_FFF0);
    write_reg(2'd2, 32'hFFFF_FFF0);
    read_reg(2'd1, v); chk("R5 ret ptr written", v, 32'h0000_3000);
    read_reg(2'd3, v); chk("R5 pending supv", v, 0);
    read_reg(2'd0, v); chk("R5 fault addr unwritable", v, 32'h0000_5678);
    read_reg(2'd2, v); chk("R5 insn ptr unwritable", v, 32'h0000_2004);
    chk("R5 supv not yet", supv, 1);
    cmd_valid = 1'b1; cmd_code = 3'd5;
    step();
    cmd_valid = 1'b0;
    chk("R10 freeze held", freeze, 1);
    chk("R10 no flush", flush, 0);
    step();
    chk("R10 still frozen", freeze, 1);
    chk("R10 no fetch", pf_start, 0);
    exit_seq(3'd2, 32'h0000_3000);
    chk("R5 supv applied", supv, 0);
    write_reg(2'd1, 32'h0000_7777);
    read_reg(2'd1, v); chk("R5 write outside halt ignored", v, 32'h0000_3000);
  endtask

  task automatic t_odd_ret();
    enter(1'b0, 32'h0000_0100);
    write_reg(2'd1, 32'h0000_0101);
    exit_seq(3'd1, 32'h0000_0101);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_dbl_after_reset();
    t_fault_addr();
    t_bkpt_entry();
    t_writes_and_call();
    t_odd_ret();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule